// File: doc/BRIEF.md
# PHY Management Frame Controller

This block lets a host reach the registers of an external Ethernet PHY through the two-wire clause-22 management bus. The host uses a small word-addressed register file. It writes a command word to start a frame. A write frame takes its 16-bit payload from the data register, and a read frame places the PHY's reply in that same register. A status bit stays high for as long as a frame is on the wire. A control register sets the management clock divisor and can drop the leading run of ones for PHYs that accept short frames. It also holds a self-clearing soft reset.

The controller produces the management clock itself, and that clock runs only while a frame is being shifted. Outgoing bits change while the clock is low. During a read, the data line is released from the turnaround onward, and the controller samples the PHY's bits while the clock is high. The data pin is split into an output value, an output enable and an input, so that a pad tristate can be built outside the block.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, status bit 0 reads 0, the data register reads 0, and the control register reads 0x4E00 (divisor field 39, which means a divisor of 40). The management clock, the output enable and the output value are all 0.
- R2: Word address 0 is the command register and always reads 0. Address 1 is the data register (bits 15:0). Address 2 is status, with bit 0 as busy. Address 3 is control: bits 15:9 hold the divisor minus one, bit 8 enables preamble suppression, and bit 0 is the soft reset.
- R3: A command write with bit 15 set starts a read, and one with only bit 14 set starts a write. If both bits are set, the read wins. If neither is set, nothing starts. The PHY address is taken from bits 9:5 and the register number from bits 4:0. Busy reads 1 starting on the cycle after the command write.
- R4: Each frame bit lasts D clocks, where D is the divisor field plus one, with a minimum of 2. The management clock is low for the first D - floor(D/2) clocks of a bit and high for the remaining floor(D/2). It stays low whenever no frame is running.
- R5: A frame is sent in this order: 32 ones (left out when bit 8 of control is set), start 01, opcode (10 for read, 01 for write), PHY address, register number, turnaround, then 16 data bits with the MSB first. Every driven bit changes only at a bit boundary, while the clock is low.
- R6: A write frame drives the turnaround as 1 then 0, followed by the data register contents that were present when the command was accepted.
- R7: A read frame releases the data line (output enable 0) for the turnaround and all data bits. It samples the input on the first clock of each data bit's high phase. The assembled word is loaded into the data register in the same cycle that busy clears.
- R8: Busy stays high for exactly 64*D cycles, or 32*D cycles with preamble suppression, and then falls.
- R9: While busy, writes to the command, data and control registers have no effect. This does not apply to a control write that sets bit 0.
- R10: A control write with bit 0 set aborts any frame at once and returns control to 0x4E00 and data to 0. Control bit 0 then reads 1 for 8 cycles and clears by itself. Every other write made during those cycles is ignored.
- R11: The output value is 0 whenever the output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Value sensed on the data line |

## Verification
Some properties are checked by assertions on every cycle. The management clock is low once busy falls. The data pin holds steady through each clock-high phase. The data register and the frame type do not move while a frame runs. The soft-reset counter counts down one step per cycle, and no frame can start while it is running. Other behaviour can only be shown by the bench's scenarios: the exact bit order of read and write frames, the odd-divisor and clamped-divisor phase splits, preamble suppression, the read-over-write priority, the reassembly of a PHY reply, and aborting a frame part-way through.

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int DIV_W      = 7,
  parameter int DIV_RESET  = 39,
  parameter int RST_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int PH_W = DIV_W + 1;
  localparam int RC_W = $clog2(RST_CYCLES + 1);
  localparam logic [1:0] A_CMD = 2'd0, A_DATA = 2'd1, A_STAT = 2'd2, A_CTRL = 2'd3;

  logic [DIV_W-1:0] div_f;
  logic             psup;
  logic [RC_W-1:0]  rst_cnt;
  logic [15:0]      data_q, rx_q, rx_nxt;
  logic [31:0]      tx_q, ctrl_rd;
  logic [6:0]       bits_left;
  logic [PH_W-1:0]  ph_cnt, dval, lval;
  logic             busy, is_rd;

  assign dval = (div_f == '0) ? PH_W'(2) : {1'b0, div_f} + PH_W'(1);
  assign lval = dval - (dval >> 1);

  logic rst_act, rst_wr, idle_ok, start, end_bit, last_bit, sample_now, cur_bit;
  assign rst_act    = rst_cnt != '0;
  assign rst_wr     = bus_wr && bus_addr == A_CTRL && bus_wdata[0];
  assign idle_ok    = !busy && !rst_act;
  assign start      = bus_wr && bus_addr == A_CMD && idle_ok && (bus_wdata[15] || bus_wdata[14]);
  assign end_bit    = busy && ph_cnt == dval - PH_W'(1);
  assign last_bit   = end_bit && bits_left == 7'd1;
  assign sample_now = busy && is_rd && bits_left <= 7'd16 && ph_cnt == lval;
  assign rx_nxt     = sample_now ? {rx_q[14:0], mdio_i} : rx_q;
  assign cur_bit    = (bits_left > 7'd32) ? 1'b1 : tx_q[31];

  assign mdc     = busy && ph_cnt >= lval;
  assign mdio_oe = busy && !(is_rd && bits_left <= 7'd18);
  assign mdio_o  = mdio_oe && cur_bit;

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[9 +: DIV_W] = div_f;
    ctrl_rd[8] = psup;
    ctrl_rd[0] = rst_act;
    case (bus_addr)
      A_DATA:  bus_rdata = {16'b0, data_q};
      A_STAT:  bus_rdata = {31'b0, busy};
      A_CTRL:  bus_rdata = ctrl_rd;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_f <= DIV_W'(DIV_RESET); psup <= 1'b0; rst_cnt <= '0;
      data_q <= '0; rx_q <= '0; tx_q <= '0; bits_left <= '0;
      ph_cnt <= '0; busy <= 1'b0; is_rd <= 1'b0;
    end else if (rst_wr) begin
      div_f <= DIV_W'(DIV_RESET); psup <= 1'b0; rst_cnt <= RC_W'(RST_CYCLES);
      data_q <= '0; rx_q <= '0; tx_q <= '0; bits_left <= '0;
      ph_cnt <= '0; busy <= 1'b0; is_rd <= 1'b0;
    end else begin
      if (rst_act) rst_cnt <= rst_cnt - RC_W'(1);
      if (busy) begin
        rx_q <= rx_nxt;
        if (end_bit) begin
          ph_cnt    <= '0;
          bits_left <= bits_left - 7'd1;
          if (bits_left <= 7'd32) tx_q <= {tx_q[30:0], 1'b0};
          if (last_bit) begin
            busy <= 1'b0;
            if (is_rd) data_q <= rx_nxt;
          end
        end else begin
          ph_cnt <= ph_cnt + PH_W'(1);
        end
      end else if (idle_ok && bus_wr) begin
        if (start) begin
          busy      <= 1'b1;
          is_rd     <= bus_wdata[15];
          ph_cnt    <= '0;
          rx_q      <= '0;
          bits_left <= psup ? 7'd32 : 7'd64;
          tx_q      <= {2'b01, bus_wdata[15] ? 2'b10 : 2'b01, bus_wdata[9:5], bus_wdata[4:0],
                        bus_wdata[15] ? 2'b11 : 2'b10, bus_wdata[15] ? 16'h0000 : data_q};
        end else if (bus_addr == A_DATA) begin
          data_q <= bus_wdata[15:0];
        end else if (bus_addr == A_CTRL) begin
          div_f <= bus_wdata[9 +: DIV_W];
          psup  <= bus_wdata[8];
        end
      end
    end
  end

  AST_MDC_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> !mdc); // R4
  AST_PIN_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && !end_bit && !rst_wr) |=> ($stable(mdio_o) && $stable(mdio_oe))); // R5
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !end_bit && !rst_wr) |=> $stable(data_q)); // R9
  AST_KIND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !end_bit && !rst_wr) |=> (busy && $stable(is_rd))); // R9
  AST_NO_START_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n) rst_act |=> !busy); // R10
  AST_RST_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_act && !rst_wr) |=> rst_cnt == $past(rst_cnt) - RC_W'(1)); // R10
endmodule

// File: tb/tb_mdio_mgmt_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_ctrl;
  localparam int RSTC = 8;

  logic clk = 0, rst_n = 0, bus_wr = 0, mdio_i = 1;
  logic [1:0] bus_addr = 2'd2;
  logic [31:0] bus_wdata = '0;
  wire [31:0] bus_rdata;
  wire mdc, mdio_o, mdio_oe;
  int compared = 0, mismatched = 0;

  mdio_mgmt_ctrl dut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #2.5 clk = ~clk;

  int m_bits[$];
  int m_busy, m_ph, m_D, m_L, m_rx, m_data, m_div, m_psup, m_rst, m_isrd, pb, pr;
  logic [15:0] pat = '0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void start_frame(int rd, int phy, int rg);
    m_bits.delete();
    if (m_psup == 0) repeat (32) m_bits.push_back(1);
    m_bits.push_back(0); m_bits.push_back(1);
    m_bits.push_back(rd ? 1 : 0); m_bits.push_back(rd ? 0 : 1);
    for (int i = 4; i >= 0; i--) m_bits.push_back((phy >> i) & 1);
    for (int i = 4; i >= 0; i--) m_bits.push_back((rg >> i) & 1);
    if (rd) begin m_bits.push_back(2); m_bits.push_back(2); end
    else begin m_bits.push_back(1); m_bits.push_back(0); end
    for (int i = 15; i >= 0; i--) m_bits.push_back(rd ? 3 : ((m_data >> i) & 1));
    m_D = (m_div + 1 < 2) ? 2 : m_div + 1;
    m_L = m_D - m_D / 2;
    m_ph = 0; m_busy = 1; m_isrd = rd; m_rx = 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_bits.delete(); m_busy = 0; m_ph = 0; m_data = 0; m_div = 39; m_psup = 0; m_rst = 0; m_isrd = 0;
      m_D = 40; m_L = 20; m_rx = 0;
    end else begin
      pb = m_busy; pr = m_rst;
      if (m_rst > 0) m_rst--;
      if (pb != 0) begin
        if (m_ph == m_L && m_bits[0] == 3) m_rx = ((m_rx << 1) | int'(mdio_i)) & 'hFFFF;
        if (m_ph == m_D - 1) begin
          void'(m_bits.pop_front());
          m_ph = 0;
          if (m_bits.size() == 0) begin
            m_busy = 0;
            if (m_isrd != 0) m_data = m_rx;
          end
        end else m_ph++;
      end
      if (bus_wr) begin
        if (bus_addr == 2'd3 && bus_wdata[0]) begin
          m_rst = RSTC; m_busy = 0; m_bits.delete(); m_data = 0; m_div = 39; m_psup = 0; m_ph = 0;
        end else if (pb == 0 && pr == 0) begin
          case (bus_addr)
            2'd0: if (bus_wdata[15]) start_frame(1, int'(bus_wdata[9:5]), int'(bus_wdata[4:0]));
                  else if (bus_wdata[14]) start_frame(0, int'(bus_wdata[9:5]), int'(bus_wdata[4:0]));
            2'd1: m_data = int'(bus_wdata[15:0]);
            2'd3: begin m_div = int'(bus_wdata[15:9]); m_psup = int'(bus_wdata[8]); end
            default: ;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    logic e_mdc, e_oe, e_o;
    if (rst_n) begin
      e_mdc = m_busy != 0 && m_ph >= m_L;
      e_oe  = m_busy != 0 && m_bits.size() > 0 && m_bits[0] < 2;
      e_o   = e_oe && m_bits[0] == 1;
      check("R4 mdc", {31'b0, mdc}, {31'b0, e_mdc});
      check("R5 R6 R11 mdio_o", {31'b0, mdio_o}, {31'b0, e_o});
      check("R7 mdio_oe", {31'b0, mdio_oe}, {31'b0, e_oe});
    end
    if (m_busy != 0 && m_bits.size() > 0 && m_bits[0] == 3) mdio_i = pat[m_bits.size() - 1];
    else mdio_i = 1'b1;
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0; bus_addr = 2'd2;
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] exp, string tag);
    @(negedge clk); bus_addr = a; #1;
    check(tag, bus_rdata, exp);
    bus_addr = 2'd2;
  endtask

  task automatic wait_idle(output int n);
    logic st;
    n = 0;
    do begin
      bus_addr = 2'd2; #1; st = bus_rdata[0];
      if (st) begin n++; @(negedge clk); end
    end while (st && n < 20000);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #1000000;
    mismatched++; compared++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(2'd2, 32'h0, "R1 status");
    rd(2'd3, 32'h4E00, "R1 ctrl default");
    rd(2'd1, 32'h0, "R1 data");
    rd(2'd0, 32'h0, "R2 cmd reads zero");

    wr(2'd3, 32'(3 << 9));
    rd(2'd3, 32'(3 << 9), "R2 ctrl");
    wr(2'd1, 32'hA5C3);
    rd(2'd1, 32'hA5C3, "R2 data");
    wr(2'd0, 32'((1 << 14) | (5 << 5) | 'h11));
    wr(2'd0, 32'((1 << 15) | (3 << 5) | 1));
    wr(2'd1, 32'h1111);
    wr(2'd3, 32'(7 << 9));
    rd(2'd3, 32'(3 << 9), "R9 ctrl unchanged while busy");
    rd(2'd1, 32'hA5C3, "R9 data unchanged while busy");
    wait_idle(n);
    rd(2'd2, 32'h0, "R9 no second frame");

    wr(2'd0, 32'((1 << 14) | (1 << 5)));
    wait_idle(n);
    check("R8 busy length D=4", n, 64 * 4);

    wr(2'd3, 32'((4 << 9) | (1 << 8)));
    pat = 16'h3C5A;
    wr(2'd0, 32'((1 << 15) | (31 << 5) | 2));
    wait_idle(n);
    check("R8 busy length suppressed D=5", n, 32 * 5);
    rd(2'd1, 32'h3C5A, "R7 read data");

    wr(2'd3, 32'h0);
    pat = 16'h8001;
    wr(2'd0, 32'((3 << 14) | (9 << 5) | 7));
    wait_idle(n);
    check("R4 clamped divisor length", n, 64 * 2);
    rd(2'd1, 32'h8001, "R3 read wins");

    wr(2'd0, 32'((2 << 5) | 3));
    rd(2'd2, 32'h0, "R3 no strobe no frame");

    wr(2'd3, 32'(4 << 9));
    wr(2'd1, 32'h0F0F);
    wr(2'd0, 32'((1 << 14) | (17 << 5) | 30));
    wait_idle(n);
    check("R8 busy length D=5", n, 64 * 5);

    wr(2'd0, 32'((1 << 14) | (2 << 5) | 4));
    repeat (20) @(negedge clk);
    wr(2'd3, 32'h1);
    rd(2'd3, 32'h4E01, "R10 reset in progress");
    rd(2'd2, 32'h0, "R10 frame aborted");
    wr(2'd1, 32'h7777);
    repeat (RSTC) @(negedge clk);
    rd(2'd3, 32'h4E00, "R10 self-clear");
    rd(2'd1, 32'h0, "R10 data cleared");

    wr(2'd0, 32'((1 << 14) | (6 << 5) | 1));
    wait_idle(n);
    check("R1 default divisor length", n, 64 * 40);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule